// File: doc/BRIEF.md
# Data-Path Register with Scan Shadow

This block is a parallel data-path register coupled with a second register of the same width that sits in a bit-serial diagnostic loop. In normal operation, the data-path register captures the parallel inputs on its own clock and presents them on tri-state outputs. The shadow register has an independent clock. On that clock it either shifts right, taking serial data in at the top and presenting its lowest bit at the serial output, or it captures the value held in the data-path register.

A single mode pin chooses the behaviour of both registers. With the mode low, the data-path clock loads the parallel pins and the shadow clock shifts. With the mode high, the data-path clock loads the shadow contents and the shadow clock captures the data-path value. A diagnostics controller uses this to scan a known pattern in, force it into the data path, then capture the data path and scan it back out for comparison. When both clocks fire together in diagnostic mode, each register takes the value the other held before the edge, so the two values are exchanged.

Top module: `scan_pipe_reg`

## Requirements
- R1: An active-low asynchronous reset `rst_n` clears both registers to zero without any clock edge, so `q_out` reads 0 while enabled and `sdo` reads 0.
- R2: With `mode` = 0, each rising edge of `pclk` loads `d_in` into the data-path register.
- R3: With `mode` = 0, each rising edge of `dclk` shifts the shadow register right by one: `sdi` enters bit W-1 and every other bit n takes the old bit n+1.
- R4: `sdo` always equals bit 0 of the shadow register, so a scan-out yields bit 0 first.
- R5: With `mode` = 1, each rising edge of `pclk` loads the shadow register contents into the data-path register.
- R6: With `mode` = 1, each rising edge of `dclk` loads the data-path register value into the shadow register.
- R7: With `mode` = 1 and rising edges on `pclk` and `dclk` at the same instant, the two registers exchange their values.
- R8: `q_out` drives the data-path register only while `oe_n` = 0. With `oe_n` = 1 it is high impedance, and the data-path register keeps loading as usual.
- R9: A `pclk` edge in mode 0 leaves the shadow register unchanged, and a `dclk` edge in mode 0 leaves the data-path register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Data-path register clock |
| dclk | input | 1 | Shadow register clock, independent of `pclk` |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | 0 selects normal load and shift; 1 selects cross-transfer |
| oe_n | input | 1 | Output enable for `q_out`, active low |
| d_in | input | W | Parallel data input |
| sdi | input | 1 | Serial input into the top bit of the shadow register |
| q_out | output | W | Tri-state parallel output of the data-path register |
| sdo | output | 1 | Serial output, bit 0 of the shadow register |

## Verification
Both registers are single flops, so each result is due one edge after its stimulus. A data-path load shows on `q_out` after the `pclk` edge that samples it. A shift or capture shows on `sdo` after the `dclk` edge. Reset and output-enable changes need no edge at all. The bench drives every input while both clocks are low, makes one clock pulse per step, and samples only after the clock has fallen again, so each check reads the state left by exactly one edge. A scan-out reads `sdo` before each shift, which returns bit 0 first and bit W-1 last.

// File: rtl/scan_pipe_pkg.sv
package scan_pipe_pkg;
  typedef enum logic {
    XFER_OFF = 1'b0,
    XFER_ON  = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/path_stage.sv
module path_stage #(
  parameter int W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  scan_pipe_pkg::xfer_mode_e sel,
  input  logic [W-1:0]              par_in,
  input  logic [W-1:0]              shadow_in,
  output logic [W-1:0]              held
);
  logic [W-1:0] next_val;

  always_comb begin
    if (sel == scan_pipe_pkg::XFER_ON) next_val = shadow_in;
    else                               next_val = par_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= next_val;
  end
endmodule

// File: rtl/shadow_stage.sv
module shadow_stage #(
  parameter int W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  scan_pipe_pkg::xfer_mode_e sel,
  input  logic                      ser_in,
  input  logic [W-1:0]              path_in,
  output logic [W-1:0]              held,
  output logic                      ser_out
);
  logic [W-1:0] shifted;
  logic [W-1:0] next_val;

  // Right shift: serial bit enters at the top.
  assign shifted[W-1] = ser_in;
  for (genvar i = 0; i < W - 1; i++) begin : g_shift
    assign shifted[i] = held[i+1];
  end

  always_comb begin
    if (sel == scan_pipe_pkg::XFER_ON) next_val = path_in;
    else                               next_val = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= next_val;
  end

  assign ser_out = held[0];
endmodule

// File: rtl/scan_pipe_reg.sv
module scan_pipe_reg #(
  parameter int W = 8
) (
  input  logic         pclk,
  input  logic         dclk,
  input  logic         rst_n,
  input  logic         mode,
  input  logic         oe_n,
  input  logic [W-1:0] d_in,
  input  logic         sdi,
  output logic [W-1:0] q_out,
  output logic         sdo
);
  scan_pipe_pkg::xfer_mode_e sel;
  logic [W-1:0] path_q;
  logic [W-1:0] shad_q;

  assign sel = mode ? scan_pipe_pkg::XFER_ON : scan_pipe_pkg::XFER_OFF;

  path_stage #(.W(W)) u_path (
    .clk      (pclk),
    .rst_n    (rst_n),
    .sel      (sel),
    .par_in   (d_in),
    .shadow_in(shad_q),
    .held     (path_q)
  );

  shadow_stage #(.W(W)) u_shadow (
    .clk    (dclk),
    .rst_n  (rst_n),
    .sel    (sel),
    .ser_in (sdi),
    .path_in(path_q),
    .held   (shad_q),
    .ser_out(sdo)
  );

  assign q_out = oe_n ? {W{1'bz}} : path_q;
endmodule

// File: rtl/scan_pipe_reg_chk.sv
module scan_pipe_reg_chk #(
  parameter int W = 8
) (
  input logic         pclk,
  input logic         dclk,
  input logic         rst_n,
  input logic         mode,
  input logic [W-1:0] d_in,
  input logic         sdi,
  input logic [W-1:0] path_q,
  input logic [W-1:0] shad_q
);
  // R2: normal load from the parallel pins
  a_r2_path_loads_pins: assert property (@(posedge pclk) disable iff (!rst_n)
    !mode |=> path_q == $past(d_in));

  // R5: diagnostic load from the shadow register
  a_r5_path_loads_shadow: assert property (@(posedge pclk) disable iff (!rst_n)
    mode |=> path_q == $past(shad_q));

  // R3: right shift with serial entry at the top
  a_r3_shadow_shifts: assert property (@(posedge dclk) disable iff (!rst_n)
    !mode |=> shad_q == {$past(sdi), $past(shad_q[W-1:1])});

  // R6: shadow captures the data-path value
  a_r6_shadow_captures: assert property (@(posedge dclk) disable iff (!rst_n)
    mode |=> shad_q == $past(path_q));
endmodule

bind scan_pipe_reg scan_pipe_reg_chk #(.W(W)) u_chk (
  .pclk  (pclk),
  .dclk  (dclk),
  .rst_n (rst_n),
  .mode  (mode),
  .d_in  (d_in),
  .sdi   (sdi),
  .path_q(path_q),
  .shad_q(shad_q)
);

// File: tb/scan_pipe_reg_tb.sv
module scan_pipe_reg_tb;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic pclk = 1'b0, dclk = 1'b0, rst_n = 1'b0, mode = 1'b0, oe_n = 1'b0, sdi = 1'b0;
  logic [W-1:0] d_in = '0;
  logic [W-1:0] q_out;
  logic sdo;

  int n_run = 0;
  int n_fail = 0;

  scan_pipe_reg #(.W(W)) u_dut (
    .pclk(pclk), .dclk(dclk), .rst_n(rst_n), .mode(mode), .oe_n(oe_n),
    .d_in(d_in), .sdi(sdi), .q_out(q_out), .sdo(sdo)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_p();
    #(HALF) pclk = 1'b1;
    #(HALF) pclk = 1'b0;
    #1;
  endtask

  task automatic pulse_d();
    #(HALF) dclk = 1'b1;
    #(HALF) dclk = 1'b0;
    #1;
  endtask

  task automatic pulse_both();
    #(HALF) begin pclk = 1'b1; dclk = 1'b1; end
    #(HALF) begin pclk = 1'b0; dclk = 1'b0; end
    #1;
  endtask

  task automatic load_path(input logic [W-1:0] v);
    mode = 1'b0; d_in = v; pulse_p();
  endtask

  task automatic scan_in(input logic [W-1:0] v);
    mode = 1'b0;
    for (int i = 0; i < W; i++) begin
      sdi = v[i];
      pulse_d();
    end
    sdi = 1'b0;
  endtask

  task automatic scan_out(output logic [W-1:0] v);
    mode = 1'b0; sdi = 1'b0;
    for (int i = 0; i < W; i++) begin
      v[i] = sdo;
      pulse_d();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; #3;
    check("R1 q_out after reset", q_out, '0);
    check("R1 sdo after reset", {{(W-1){1'b0}}, sdo}, '0);
    rst_n = 1'b1; #2;
  endtask

  task automatic t_normal_load();
    load_path(8'hA5);
    check("R2 pins loaded", q_out, 8'hA5);
    check("R9 shadow untouched by pclk", {{(W-1){1'b0}}, sdo}, '0);
    load_path(8'h0F);
    check("R2 second load", q_out, 8'h0F);
  endtask

  task automatic t_inject();
    logic [W-1:0] v;
    scan_in(8'h3D);
    check("R4 sdo is bit0 after scan-in", {{(W-1){1'b0}}, sdo}, 8'h01);
    check("R9 path untouched by dclk", q_out, 8'h0F);
    mode = 1'b1; pulse_p();
    check("R5 injected pattern on q_out", q_out, 8'h3D);
    scan_out(v);
    check("R3 scan-out of injected pattern", v, 8'h3D);
  endtask

  task automatic t_capture();
    logic [W-1:0] v;
    load_path(8'h96);
    mode = 1'b1; pulse_d();
    check("R6 capture bit0 on sdo", {{(W-1){1'b0}}, sdo}, 8'h00);
    check("R6 path kept by capture", q_out, 8'h96);
    scan_out(v);
    check("R4 scan-out of captured value", v, 8'h96);
  endtask

  task automatic t_swap();
    logic [W-1:0] v;
    load_path(8'h5A);
    mode = 1'b1; pulse_d();
    load_path(8'hC3);
    mode = 1'b1; pulse_both();
    check("R7 path took old shadow", q_out, 8'h5A);
    scan_out(v);
    check("R7 shadow took old path", v, 8'hC3);
  endtask

  task automatic t_oe();
    load_path(8'hA5);
    oe_n = 1'b1; #1;
    n_run++;
    if (q_out === 8'hA5) begin
      n_fail++;
      $display("FAIL R8 q_out driven while disabled actual=%h expected=zz", q_out);
    end
    load_path(8'h77);
    oe_n = 1'b0; #1;
    check("R8 load while disabled", q_out, 8'h77);
  endtask

  task automatic t_async_reset();
    scan_in(8'hFF);
    load_path(8'hE1);
    #2 rst_n = 1'b0; #2;
    check("R1 async clear of path", q_out, '0);
    check("R1 async clear of shadow", {{(W-1){1'b0}}, sdo}, '0);
    rst_n = 1'b1; #2;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_normal_load();
    t_inject();
    t_capture();
    t_swap();
    t_oe();
    t_async_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule